// File: doc/BRIEF.md
# Round-Robin Conversion Start Arbiter

This block decides which of sixteen conversion slots gets the one shared conversion engine next. Each slot is enabled on its own and picks one of several trigger inputs. When its trigger pulses, the slot raises a pending flag, and one pulse can raise the flags of every slot that listens to it in the same cycle. The engine serves one slot at a time. It holds that slot for its acquisition window plus a fixed conversion time, then files the result under the slot's own number.

A programmable threshold splits the slots into two classes. Slots numbered below the threshold form an urgent class, served lowest number first. All other slots share the engine in rotation. The rotation resumes just after the last rotating slot that finished, and a new trigger never moves that position. As a result, the order of a burst depends on where the previous burst ended. Setting the threshold so the early slots are urgent makes the order fixed.

A stand-in data model supplies the converted value. Each result holds the slot number in its upper bits and a running count of completed conversions in its lower bits.

Top module: `soc_rr_sequencer`

## Requirements
- R1: An enabled slot whose 2-bit trigger select names a trigger input that pulses becomes pending. All slots sharing that input become pending in the same cycle. A disabled slot never converts.
- R2: With threshold T (0 to 16), slots 0..T-1 are urgent. Any pending urgent slot is granted before every rotating slot, and urgent slots are granted in ascending number order. T=16 makes all slots urgent.
- R3: Rotating slots are searched from rotation position + 1 upward, wrapping from 15 to 0 and skipping slots that are not pending. The first pending slot found is granted.
- R4: The rotation position is 15 after reset. It changes only when a rotating slot finishes, and it then takes that slot's number. Triggers and urgent conversions leave it unchanged.
- R5: A trigger that arrives during a conversion only marks its slot pending. The running conversion continues to its end, and the new slot competes at the next grant.
- R6: A conversion keeps `busy` high for (acquisition setting + 15) cycles. A grant occurs on the first clock edge at which the engine is idle and any slot is pending. From an idle engine, `conv_start` appears two cycles after the trigger pulse.
- R7: Each result is written to the result register indexed by slot number. Its value is {slot[3:0], count[7:0]}, where count is the number of conversions completed before it. Registers of slots that never converted read 0.
- R8: A trigger on a slot that is still pending sets that slot's overflow flag. The flag stays set until reset and causes no extra conversion.
- R9: `conv_start` pulses for one cycle with `conv_slot` naming the granted slot. When that conversion ends, `done_pulse` carries exactly one bit, the bit of that slot, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 4 | Trigger pulses, one per source |
| slot_en | input | 16 | Per-slot enable |
| slot_trig_sel | input | 32 | 2-bit trigger select per slot, slot k at bits [2k+1:2k] |
| slot_acq | input | 96 | 6-bit acquisition setting per slot, slot k at bits [6k+5:6k] |
| prio_thresh | input | 5 | Number of low-numbered urgent slots (0..16) |
| rd_sel | input | 4 | Result register to read |
| rd_data | output | 12 | Contents of the selected result register |
| busy | output | 1 | Engine is converting |
| conv_start | output | 1 | One-cycle pulse on each grant |
| conv_slot | output | 4 | Slot being converted |
| done_pulse | output | 16 | One-hot completion pulse |
| ovf_flags | output | 16 | Sticky per-slot trigger overflow |

## Verification
The assertions check the following on every cycle: pending flags hold until granted, overflow flags are sticky, the rotation position moves only at the end of a rotating conversion, and a conversion keeps its slot until it ends. They also check that an idle engine with pending work grants at once, that urgent slots win whenever one was pending, and that completion pulses are one-hot. Only the bench scenarios can show the full order of a burst. These include the order that starts mid-way because the previous burst ended on a late slot, the fixed order once the threshold is raised, and the rotation position surviving an all-urgent round. The scenarios also check each conversion's length and the result value filed under each slot.

// File: rtl/soc_seq_pkg.sv
// Shared types and constants for the conversion start arbiter.
package soc_seq_pkg;
    // Engine occupancy state
    typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} eng_state_t;
    // Fixed conversion cycles added to acquisition setting + 1
    localparam int CONV_CYCLES = 14;
endpackage

// File: rtl/soc_pend_latch.sv
// Per-slot pending and overflow flags.
// Assumes trigger pulses are synchronous to clk; a hit and a clear in the
// same cycle leave the slot pending (the new trigger is kept).
module soc_pend_latch #(
    parameter int N      = 16,
    parameter int NT     = 4,
    parameter int TSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     trig,
    input  logic [N-1:0]      en,
    input  logic [N*TSEL_W-1:0] sel,
    input  logic [N-1:0]      clr,
    output logic [N-1:0]      pend,
    output logic [N-1:0]      ovf
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit;
        // Decode this slot's selected trigger
        assign hit = en[i] & trig[sel[i*TSEL_W +: TSEL_W]];

        // Track pending and sticky overflow for this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                ovf[i]  <= 1'b0;
            end else begin
                pend[i] <= (pend[i] & ~clr[i]) | hit;
                if (hit && pend[i] && !clr[i]) ovf[i] <= 1'b1;
            end
        end

        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]); // R1
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> ovf[i]); // R8
    end
endmodule

// File: rtl/soc_pick.sv
// Combinational winner selection: lowest pending urgent slot first,
// otherwise the first pending rotating slot after the rotation position.
// Assumes N is the slot count and thr ranges 0..N.
module soc_pick #(
    parameter int N      = 16,
    parameter int SLOT_W = 4,
    parameter int THR_W  = 5
) (
    input  logic [N-1:0]      pend,
    input  logic [SLOT_W-1:0] ptr,
    input  logic [THR_W-1:0]  thr,
    output logic              valid,
    output logic [SLOT_W-1:0] win
);
    logic              hp_hit, rr_hit;
    logic [SLOT_W-1:0] hp_idx, rr_idx;

    // Scan both classes; later matches in each loop have higher precedence
    always_comb begin
        int j;
        hp_hit = 1'b0;
        rr_hit = 1'b0;
        hp_idx = '0;
        rr_idx = '0;
        j      = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && (i < int'(thr))) begin
                hp_hit = 1'b1;
                hp_idx = SLOT_W'(i);
            end
        end
        for (int k = N; k >= 1; k--) begin
            j = (int'(ptr) + k) % N;
            if (pend[j] && (j >= int'(thr))) begin
                rr_hit = 1'b1;
                rr_idx = SLOT_W'(j);
            end
        end
        valid = hp_hit | rr_hit;
        win   = hp_hit ? hp_idx : rr_idx;
    end
endmodule

// File: rtl/soc_engine.sv
// Conversion engine timer: accepts a grant when idle and stays busy for
// acquisition + 1 + CONV_CYCLES cycles. Never preempted.
module soc_engine
    import soc_seq_pkg::*;
#(
    parameter int N      = 16,
    parameter int SLOT_W = 4,
    parameter int ACQ_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pick_valid,
    input  logic [SLOT_W-1:0]  pick_slot,
    input  logic [N*ACQ_W-1:0] acq_flat,
    output logic               busy,
    output logic               grant,
    output logic               start_pulse,
    output logic [SLOT_W-1:0]  cur_slot,
    output logic               finish
);
    localparam int CNT_W = ACQ_W + 2;

    eng_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [ACQ_W-1:0] acq_sel;

    assign acq_sel = acq_flat[int'(pick_slot)*ACQ_W +: ACQ_W];
    assign busy    = (state == ENG_RUN);
    assign grant   = !busy && pick_valid;
    assign finish  = busy && (cnt == '0);

    // Load, count down and release the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ENG_IDLE;
            cnt         <= '0;
            cur_slot    <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= grant;
            if (grant) begin
                state    <= ENG_RUN;
                cur_slot <= pick_slot;
                cnt      <= CNT_W'(acq_sel) + CNT_W'(CONV_CYCLES);
            end else if (finish) begin
                state <= ENG_IDLE;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> (busy && $stable(cur_slot))); // R5
endmodule

// File: rtl/soc_result_bank.sv
// Slot-indexed result registers fed by a stand-in data model:
// value = {slot, running completion count}.
module soc_result_bank #(
    parameter int N      = 16,
    parameter int SLOT_W = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SLOT_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SEQ_W = DATA_W - SLOT_W;

    logic [DATA_W-1:0] res [N];
    logic [SEQ_W-1:0]  seq;

    // Store the modelled sample and advance the completion count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq <= '0;
            for (int i = 0; i < N; i++) res[i] <= '0;
        end else if (wr_en) begin
            res[wr_slot] <= {wr_slot, seq};
            seq          <= seq + 1'b1;
        end
    end

    assign rd_data = res[rd_sel];
endmodule

// File: rtl/soc_rr_sequencer.sv
// Top: sixteen start-of-conversion slots sharing one engine, with an urgent
// low-numbered class and a persistent rotation position for the rest.
// Assumes prio_thresh and slot settings change only while idle.
module soc_rr_sequencer #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 4,
    parameter int ACQ_W     = 6,
    parameter int DATA_W    = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int TSEL_W   = $clog2(NUM_TRIG),
    localparam int THR_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TRIG-1:0]         trig_in,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    input  logic [NUM_SLOTS*TSEL_W-1:0] slot_trig_sel,
    input  logic [NUM_SLOTS*ACQ_W-1:0]  slot_acq,
    input  logic [THR_W-1:0]            prio_thresh,
    input  logic [SLOT_W-1:0]           rd_sel,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        busy,
    output logic                        conv_start,
    output logic [SLOT_W-1:0]           conv_slot,
    output logic [NUM_SLOTS-1:0]        done_pulse,
    output logic [NUM_SLOTS-1:0]        ovf_flags
);
    logic [NUM_SLOTS-1:0] pend, clr, hp_mask;
    logic                 pick_valid, grant, finish;
    logic [SLOT_W-1:0]    pick_slot, rr_ptr;

    assign clr = grant ? (NUM_SLOTS'(1) << pick_slot) : '0;

    soc_pend_latch #(.N(NUM_SLOTS), .NT(NUM_TRIG), .TSEL_W(TSEL_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .trig(trig_in), .en(slot_en),
        .sel(slot_trig_sel), .clr(clr), .pend(pend), .ovf(ovf_flags)
    );

    soc_pick #(.N(NUM_SLOTS), .SLOT_W(SLOT_W), .THR_W(THR_W)) u_pick (
        .pend(pend), .ptr(rr_ptr), .thr(prio_thresh),
        .valid(pick_valid), .win(pick_slot)
    );

    soc_engine #(.N(NUM_SLOTS), .SLOT_W(SLOT_W), .ACQ_W(ACQ_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_slot(pick_slot),
        .acq_flat(slot_acq), .busy(busy), .grant(grant),
        .start_pulse(conv_start), .cur_slot(conv_slot), .finish(finish)
    );

    soc_result_bank #(.N(NUM_SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(finish), .wr_slot(conv_slot),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Rotation position follows only completed rotating slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= SLOT_W'(NUM_SLOTS - 1);
        end else if (finish && (int'(conv_slot) >= int'(prio_thresh))) begin
            rr_ptr <= conv_slot;
        end
    end

    // Completion pulse for the slot that just finished
    always_ff @(posedge clk) begin
        if (!rst_n) done_pulse <= '0;
        else        done_pulse <= finish ? (NUM_SLOTS'(1) << conv_slot) : '0;
    end

    // Urgent-class mask, used by the checks below
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) hp_mask[i] = (i < int'(prio_thresh));
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(rr_ptr)); // R4
    AST_HP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(|(pend & hp_mask))) |-> (int'(conv_slot) < int'(prio_thresh))); // R2
    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (|pend)) |=> conv_start); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R9
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse)); // R9
endmodule

// File: tb/sim_soc_rr_sequencer.sv
module sim_soc_rr_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trig_in = '0;
    logic [15:0] slot_en;
    logic [31:0] slot_trig_sel;
    logic [95:0] slot_acq;
    logic [4:0]  prio_thresh = '0;
    logic [3:0]  rd_sel = '0;
    logic [11:0] rd_data;
    logic        busy, conv_start;
    logic [3:0]  conv_slot;
    logic [15:0] done_pulse, ovf_flags;

    int checks = 0, fails = 0, starts = 0, dones = 0, cyc = 0;
    int start_cyc = 0, cur = -1;
    bit finished = 1'b0;
    int    slot_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    soc_rr_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .slot_en(slot_en),
        .slot_trig_sel(slot_trig_sel), .slot_acq(slot_acq),
        .prio_thresh(prio_thresh), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .conv_start(conv_start), .conv_slot(conv_slot),
        .done_pulse(done_pulse), .ovf_flags(ovf_flags)
    );

    function automatic int acq_of(int s);
        return s % 4;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int s, string req);
        slot_q.push_back(s);
        tag_q.push_back(req);
    endtask

    task automatic pulse(int t);
        @(negedge clk); trig_in[t] = 1'b1;
        @(negedge clk); trig_in[t] = 1'b0;
    endtask

    task automatic wait_starts(int n);
        while (starts < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (slot_q.size() != 0 || busy || cur != -1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor / scoreboard: order, duration and stored value
    always @(negedge clk) begin
        cyc++;
        if (rst_n && conv_start) begin
            if (slot_q.size() == 0) begin
                chk(1'b0, "R1/R3", "unexpected start slot", conv_slot, -1);
            end else begin
                int    es;
                string et;
                es = slot_q.pop_front();
                et = tag_q.pop_front();
                chk(int'(conv_slot) == es, et, "grant order slot", conv_slot, es);
            end
            chk(cur == -1, "R5", "start while previous conversion open", cur, -1);
            cur = conv_slot;
            start_cyc = cyc;
            starts++;
        end
        if (rst_n && done_pulse != 0) begin
            int ds;
            ds = -1;
            for (int i = 0; i < 16; i++) if (done_pulse[i]) ds = i;
            chk($countones(done_pulse) == 1 && ds == cur, "R9", "done slot", ds, cur);
            chk(cyc - start_cyc == acq_of(ds) + 15, "R6", "conversion length",
                cyc - start_cyc, acq_of(ds) + 15);
            rd_sel = 4'(ds);
            #1;
            chk(int'(rd_data) == ((ds << 8) | (dones & 255)), "R7", "result value",
                rd_data, (ds << 8) | (dones & 255));
            dones++;
            cur = -1;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++; checks++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", starts, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        slot_en       = 16'h02FF;
        slot_trig_sel = '1;
        slot_acq      = '0;
        for (int s = 0; s < 16; s++) begin
            slot_acq[s*6 +: 6] = 6'(acq_of(s));
            if (s <= 7 || s == 10) slot_trig_sel[s*2 +: 2] = 2'd0;
        end
        slot_trig_sel[4*2 +: 2] = 2'd1;
        slot_trig_sel[9*2 +: 2] = 2'd2;
        slot_en[10] = 1'b0;               // R1: disabled slot shares trigger 0
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_sel = 4'd10;
        #1;
        chk(busy == 0 && conv_start == 0, "R9", "reset idle", busy, 0);
        chk(done_pulse == 0 && ovf_flags == 0, "R8", "reset flags", ovf_flags, 0);
        chk(rd_data == 0, "R7", "reset result", rd_data, 0);

        // Round A: thr=0, slot 4 trigger arrives late; start from position 15
        prio_thresh = 5'd0;
        foreach (slot_q[i]) ; // no-op
        push(0, "R1/R3"); push(1, "R3"); push(2, "R3"); push(3, "R3");
        push(5, "R3"); push(6, "R3"); push(7, "R3"); push(4, "R5");
        @(negedge clk); trig_in[0] = 1'b1;
        @(negedge clk); trig_in[0] = 1'b0;
        @(negedge clk);
        chk(conv_start == 1 && conv_slot == 0, "R6", "grant latency from idle", conv_start, 1);
        wait_starts(7);
        pulse(1);
        wait_idle();

        // Round B: position left at 4, burst resumes at slot 5
        push(5, "R3/R4"); push(6, "R3"); push(7, "R3"); push(0, "R3");
        push(1, "R3"); push(2, "R3"); push(3, "R3"); push(4, "R5");
        pulse(0);
        wait_starts(8 + 7);
        pulse(1);
        wait_idle();

        // Round C: thr=4, urgent 0..3 first; double trigger on slot 9
        prio_thresh = 5'd4;
        push(0, "R2"); push(1, "R2"); push(2, "R2"); push(3, "R2");
        push(5, "R3"); push(6, "R3"); push(7, "R3"); push(9, "R8"); push(4, "R3");
        pulse(0);
        wait_starts(16 + 1);
        pulse(2);
        @(negedge clk);
        pulse(2);
        wait_starts(16 + 8);
        pulse(1);
        wait_idle();
        chk(ovf_flags == 16'h0200, "R8", "overflow flags", ovf_flags, 16'h0200);

        // Round D: thr=16, all urgent, strict ascending order
        prio_thresh = 5'd16;
        for (int s = 0; s < 8; s++) push(s, "R2");
        pulse(0);
        wait_starts(25 + 1);
        pulse(1);
        wait_idle();

        // Round E: thr=0 again; position still 4 from round C
        prio_thresh = 5'd0;
        push(5, "R4"); push(6, "R4"); push(7, "R4"); push(0, "R4");
        push(1, "R4"); push(2, "R4"); push(3, "R4");
        pulse(0);
        wait_idle();

        chk(slot_q.size() == 0, "R3", "expected grants left", slot_q.size(), 0);
        rd_sel = 4'd10;
        #1;
        chk(rd_data == 0, "R1", "disabled slot result", rd_data, 0);
        rd_sel = 4'd8;
        #1;
        chk(rd_data == 0, "R7", "untriggered slot result", rd_data, 0);
        chk(starts == 40, "R1", "total conversions", starts, 40);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule